// File: doc/BRIEF.md
# NAND Operation Launch Engine

This block runs one NAND bus operation at a time on behalf of software. Software fills a command holding register or an address holding register, picks one of the internal page buffers, and then writes a one-hot launch code. The engine carries out exactly one of six operations: a command latch cycle, an address latch cycle, a page program transfer from a buffer to the device, a page fetch from the device into a buffer, an identifier read, or a status read.

A sticky completion flag tells software that the operation has ended. Software polls the flag and clears it by writing. The engine drives the NAND pins itself (command latch, address latch, write strobe, read strobe, chip enable) with fixed strobe timing. Before any data strobe it waits for the device's ready/busy line to read ready.

Software reaches the page buffers through a byte-wide port. Reads on that port, and register reads, return data one clock after the address is presented.

Top module: `nand_op_engine`

## Requirements
- R1: After reset, busy is low, the completion flag is clear, every register reads 0, chip enable and both strobes are high, and both latch enables and the data output enable are low.
- R2: Register offsets are: command = 0, address = 1, buffer select = 2, control = 3, launch = 4. Writing 0x0001 to the launch register produces exactly one write-strobe pulse, with command latch high, address latch low, and the data bus carrying bits [7:0] of the command register.
- R3: Launch code 0x0002 produces exactly one write-strobe pulse, with address latch high, command latch low, and the data bus carrying bits [7:0] of the address register.
- R4: Launch code 0x0004 sends every byte of the selected buffer, in ascending index order, as write-strobe pulses with both latch enables low.
- R5: Launch code 0x0008 issues one read-strobe pulse per page byte and stores each sampled byte at ascending indices of the selected buffer.
- R6: Launch code 0x0010 issues ID_BYTES read-strobe pulses and stores the bytes at indices 0 and up of the selected buffer. Later bytes of that buffer are left unchanged.
- R7: Launch code 0x0020 issues one read-strobe pulse and stores the status byte at index 0 of the selected buffer. Index 1 is left unchanged.
- R8: Bit 15 of the launch register is the completion flag. It sets when an operation ends and stays set through reads and through writes that have bit 15 set. A write with bit 15 clear, accepted while the engine is idle, clears it.
- R9: Busy is high from the clock after a launch is accepted until the operation ends. While busy, the launch register reads the active code in bits [5:0]. Launch-register writes made while busy are ignored. A code whose bits [5:0] do not have exactly one bit set starts nothing. No strobe pulses while idle.
- R10: The four data transfers (codes 0x04, 0x08, 0x10, 0x20) issue no strobe pulse while the ready/busy input is low, and they proceed once it goes high.
- R11: Every write-strobe or read-strobe low pulse lasts exactly PULSE_CLKS clocks. The two strobes are never low together.
- R12: The control register keeps only bits 2 to 8; all other bits read as 0. Chip enable is low while busy or while control bit 7 is set.
- R13: Bits [BW-1:0] of the buffer-select register choose the buffer (BW = log2 NUM_BUFS). Higher bits are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one clock after the address |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_sel | input | BW | Buffer index for software access |
| buf_addr | input | PW | Byte index within the buffer |
| buf_wdata | input | 8 | Buffer write byte |
| buf_rdata | output | 8 | Buffer read byte, one clock after the address |
| busy | output | 1 | Operation in progress |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus driven to the device |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus from the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The assertions assume that the ready/busy input falls only while the engine is idle or waiting before a data transfer, and never in the middle of a byte train. They also assume that no command or address launch is made while the device reports busy. The stimulus meets both conditions: it pulls ready/busy low only before launching a data transfer, and releases it once during that transfer. The stimulus also never writes a buffer that a running transfer is using, so the buffer contents it predicts stay valid.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;

  typedef enum logic [1:0] {
    BK_CMD,
    BK_ADDR,
    BK_WRITE,
    BK_READ
  } bus_kind_t;

  localparam logic [2:0] RA_CMD    = 3'd0;
  localparam logic [2:0] RA_ADDR   = 3'd1;
  localparam logic [2:0] RA_BUFSEL = 3'd2;
  localparam logic [2:0] RA_CTRL   = 3'd3;
  localparam logic [2:0] RA_LAUNCH = 3'd4;

  localparam logic [5:0] OP_CMD   = 6'h01;
  localparam logic [5:0] OP_ADDR  = 6'h02;
  localparam logic [5:0] OP_PROG  = 6'h04;
  localparam logic [5:0] OP_FETCH = 6'h08;
  localparam logic [5:0] OP_ID    = 6'h10;
  localparam logic [5:0] OP_STAT  = 6'h20;

  localparam int          DONE_BIT     = 15;
  localparam int          CE_FORCE_BIT = 7;
  localparam logic [15:0] CTRL_MASK    = 16'h01FC;

endpackage

// File: rtl/nand_bus_phy.sv
module nand_bus_phy
  import nand_eng_pkg::*;
#(
  parameter int PULSE_CLKS = 3,
  parameter int HOLD_CLKS  = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  bus_kind_t kind,
  input  logic [7:0] wdata,
  input  logic [7:0] dq_in,
  output logic      ack,
  output logic [7:0] rdata,
  output logic      cle,
  output logic      ale,
  output logic      we_n,
  output logic      re_n,
  output logic [7:0] dq_out,
  output logic      dq_oe
);

  localparam int MAXC = (PULSE_CLKS > HOLD_CLKS) ? PULSE_CLKS : HOLD_CLKS;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {PS_IDLE, PS_SETUP, PS_LOW, PS_HIGH} phy_st_t;

  phy_st_t       st;
  logic [CW-1:0] cnt;
  logic          is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PS_IDLE;
      cnt    <= '0;
      is_rd  <= 1'b0;
      ack    <= 1'b0;
      rdata  <= 8'h00;
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      dq_out <= 8'h00;
      dq_oe  <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st)
        PS_IDLE: begin
          if (req) begin
            cle    <= (kind == BK_CMD);
            ale    <= (kind == BK_ADDR);
            is_rd  <= (kind == BK_READ);
            dq_oe  <= (kind != BK_READ);
            dq_out <= wdata;
            st     <= PS_SETUP;
          end
        end
        PS_SETUP: begin
          if (is_rd) re_n <= 1'b0;
          else       we_n <= 1'b0;
          cnt <= CW'(PULSE_CLKS - 1);
          st  <= PS_LOW;
        end
        PS_LOW: begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (is_rd) rdata <= dq_in;
            cnt <= CW'(HOLD_CLKS - 1);
            st  <= PS_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            cle   <= 1'b0;
            ale   <= 1'b0;
            dq_oe <= 1'b0;
            ack   <= 1'b1;
            st    <= PS_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nand_page_ram.sv
module nand_page_ram #(
  parameter int NUM_BUFS   = 2,
  parameter int PAGE_BYTES = 16,
  parameter int AW         = $clog2(NUM_BUFS * PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);

  localparam int DEPTH = NUM_BUFS * PAGE_BYTES;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/nand_op_ctrl.sv
module nand_op_ctrl
  import nand_eng_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int ID_BYTES   = 4,
  parameter int PW         = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [5:0]    op_in,
  input  logic [7:0]    byte_in,
  input  logic          nand_rb,
  input  logic          phy_ack,
  input  logic [7:0]    phy_rdata,
  input  logic [7:0]    ram_rdata,
  output logic          busy,
  output logic          finish,
  output logic [5:0]    op_act,
  output logic          phy_req,
  output bus_kind_t     phy_kind,
  output logic [7:0]    phy_wdata,
  output logic          ram_we,
  output logic [PW-1:0] ram_idx,
  output logic [7:0]    ram_wdata
);

  typedef enum logic [2:0] {C_IDLE, C_RB, C_FETCH, C_ISSUE, C_WAIT, C_DONE} ctl_st_t;

  ctl_st_t       st;
  logic [5:0]    op_q;
  logic [7:0]    byte_q;
  logic [PW-1:0] idx_q;
  logic [PW-1:0] last_q;
  logic          is_read;
  logic          is_single;

  assign is_read   = |(op_q & (OP_FETCH | OP_ID | OP_STAT));
  assign is_single = |(op_q & (OP_CMD | OP_ADDR));

  always_comb begin
    if (op_q == OP_CMD)       phy_kind = BK_CMD;
    else if (op_q == OP_ADDR) phy_kind = BK_ADDR;
    else if (op_q == OP_PROG) phy_kind = BK_WRITE;
    else                      phy_kind = BK_READ;
  end

  assign phy_req   = (st == C_ISSUE);
  assign phy_wdata = (phy_kind == BK_WRITE) ? ram_rdata : byte_q;
  assign ram_idx   = idx_q;
  assign ram_we    = (st == C_WAIT) && phy_ack && is_read;
  assign ram_wdata = phy_rdata;
  assign busy      = (st != C_IDLE);
  assign finish    = (st == C_DONE);
  assign op_act    = busy ? op_q : 6'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= C_IDLE;
      op_q   <= 6'h00;
      byte_q <= 8'h00;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      case (st)
        C_IDLE: begin
          if (start) begin
            op_q   <= op_in;
            byte_q <= byte_in;
            idx_q  <= '0;
            if (op_in == OP_PROG || op_in == OP_FETCH) last_q <= PW'(PAGE_BYTES - 1);
            else if (op_in == OP_ID)                   last_q <= PW'(ID_BYTES - 1);
            else                                       last_q <= '0;
            st <= ((op_in == OP_CMD) || (op_in == OP_ADDR)) ? C_ISSUE : C_RB;
          end
        end
        C_RB: begin
          if (nand_rb) st <= (op_q == OP_PROG) ? C_FETCH : C_ISSUE;
        end
        C_FETCH: st <= C_ISSUE;
        C_ISSUE: st <= C_WAIT;
        C_WAIT: begin
          if (phy_ack) begin
            if (is_single || idx_q == last_q) begin
              st <= C_DONE;
            end else begin
              idx_q <= idx_q + 1'b1;
              st    <= (op_q == OP_PROG) ? C_FETCH : C_ISSUE;
            end
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
  import nand_eng_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int ID_BYTES   = 4,
  parameter int NUM_BUFS   = 2,
  parameter int PULSE_CLKS = 3,
  parameter int HOLD_CLKS  = 2,
  parameter int BW         = $clog2(NUM_BUFS),
  parameter int PW         = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          buf_we,
  input  logic [BW-1:0] buf_sel,
  input  logic [PW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic          busy,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [7:0]    nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [7:0]    nand_dq_in,
  input  logic          nand_rb
);

  localparam int AW = BW + PW;

  logic [15:0]   cmd_q;
  logic [15:0]   addr_q;
  logic [BW-1:0] bufsel_q;
  logic [BW-1:0] xfer_buf_q;
  logic [15:0]   ctrl_q;
  logic          done_q;

  logic          launch_wr;
  logic          start;
  logic          finish;
  logic [5:0]    op_act;
  logic          phy_req;
  bus_kind_t     phy_kind;
  logic [7:0]    phy_wdata;
  logic          phy_ack;
  logic [7:0]    phy_rdata;
  logic          ram_we;
  logic [PW-1:0] ram_idx;
  logic [7:0]    ram_wdata;
  logic [7:0]    ram_rdata;
  logic [7:0]    start_byte;

  assign launch_wr  = reg_we && (reg_addr == RA_LAUNCH) && !busy;
  assign start      = launch_wr && $onehot(reg_wdata[5:0]);
  assign start_byte = reg_wdata[0] ? cmd_q[7:0] : addr_q[7:0];
  assign nand_ce_n  = !(busy || ctrl_q[CE_FORCE_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= 16'h0000;
      addr_q     <= 16'h0000;
      bufsel_q   <= '0;
      xfer_buf_q <= '0;
      ctrl_q     <= 16'h0000;
      done_q     <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_CMD:    cmd_q    <= reg_wdata;
          RA_ADDR:   addr_q   <= reg_wdata;
          RA_BUFSEL: bufsel_q <= reg_wdata[BW-1:0];
          RA_CTRL:   ctrl_q   <= reg_wdata & CTRL_MASK;
          default: ;
        endcase
      end
      if (launch_wr && !reg_wdata[DONE_BIT]) done_q <= 1'b0;
      if (start) xfer_buf_q <= bufsel_q;
      if (finish) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 16'h0000;
    end else begin
      case (reg_addr)
        RA_CMD:    reg_rdata <= cmd_q;
        RA_ADDR:   reg_rdata <= addr_q;
        RA_BUFSEL: reg_rdata <= 16'(bufsel_q);
        RA_CTRL:   reg_rdata <= ctrl_q;
        RA_LAUNCH: reg_rdata <= {done_q, 9'b0, op_act};
        default:   reg_rdata <= 16'h0000;
      endcase
    end
  end

  nand_op_ctrl #(
    .PAGE_BYTES(PAGE_BYTES),
    .ID_BYTES  (ID_BYTES),
    .PW        (PW)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op_in    (reg_wdata[5:0]),
    .byte_in  (start_byte),
    .nand_rb  (nand_rb),
    .phy_ack  (phy_ack),
    .phy_rdata(phy_rdata),
    .ram_rdata(ram_rdata),
    .busy     (busy),
    .finish   (finish),
    .op_act   (op_act),
    .phy_req  (phy_req),
    .phy_kind (phy_kind),
    .phy_wdata(phy_wdata),
    .ram_we   (ram_we),
    .ram_idx  (ram_idx),
    .ram_wdata(ram_wdata)
  );

  nand_bus_phy #(
    .PULSE_CLKS(PULSE_CLKS),
    .HOLD_CLKS (HOLD_CLKS)
  ) phy_i (
    .clk   (clk),
    .rst   (rst),
    .req   (phy_req),
    .kind  (phy_kind),
    .wdata (phy_wdata),
    .dq_in (nand_dq_in),
    .ack   (phy_ack),
    .rdata (phy_rdata),
    .cle   (nand_cle),
    .ale   (nand_ale),
    .we_n  (nand_we_n),
    .re_n  (nand_re_n),
    .dq_out(nand_dq_out),
    .dq_oe (nand_dq_oe)
  );

  nand_page_ram #(
    .NUM_BUFS  (NUM_BUFS),
    .PAGE_BYTES(PAGE_BYTES),
    .AW        (AW)
  ) ram_i (
    .clk    (clk),
    .a_we   (buf_we),
    .a_addr ({buf_sel, buf_addr}),
    .a_wdata(buf_wdata),
    .a_rdata(buf_rdata),
    .b_we   (ram_we),
    .b_addr ({xfer_buf_q, ram_idx}),
    .b_wdata(ram_wdata),
    .b_rdata(ram_rdata)
  );

endmodule

// File: rtl/nand_op_engine_chk.sv
module nand_op_engine_chk #(
  parameter int PULSE_CLKS = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done_q,
  input logic [5:0] op_act,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic       reg_wdata_15,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_ce_n,
  input logic       nand_rb
);

  logic [15:0] low_cnt;
  logic        strobes_high;
  logic        clr_write;
  logic        data_op;

  assign strobes_high = nand_we_n && nand_re_n;
  assign clr_write    = reg_we && (reg_addr == 3'd4) && !reg_wdata_15 && !busy;
  assign data_op      = ((op_act & 6'h3C) != 6'h00);

  always_ff @(posedge clk) begin
    if (rst)               low_cnt <= 16'h0000;
    else if (!strobes_high) low_cnt <= low_cnt + 16'h0001;
    else                   low_cnt <= 16'h0000;
  end

  p_no_dual_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  p_pulse_width_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(strobes_high) |-> (low_cnt == 16'(PULSE_CLKS)));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clr_write) |=> done_q);

  p_done_on_end_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_q);

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> strobes_high);

  p_ce_busy_r12: assert property (@(posedge clk) disable iff (rst)
    busy |-> !nand_ce_n);

  p_rb_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && data_op && !nand_rb) |-> strobes_high);

endmodule

bind nand_op_engine nand_op_engine_chk #(.PULSE_CLKS(PULSE_CLKS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .done_q      (done_q),
  .op_act      (op_act),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata_15(reg_wdata[15]),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_ce_n   (nand_ce_n),
  .nand_rb     (nand_rb)
);

// File: tb/nand_op_engine_tb_top.sv
`timescale 1ns/1ps
module nand_op_engine_tb_top;

  localparam int PAGE  = 16;
  localparam int IDN   = 4;
  localparam int NBUF  = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        buf_we = 1'b0;
  logic [0:0]  buf_sel = 1'b0;
  logic [3:0]  buf_addr = 4'd0;
  logic [7:0]  buf_wdata = 8'h0;
  logic [7:0]  buf_rdata;
  logic        busy;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in;
  logic        nand_rb = 1'b1;

  always #2 clk = ~clk;

  nand_op_engine #(
    .PAGE_BYTES(PAGE), .ID_BYTES(IDN), .NUM_BUFS(NBUF),
    .PULSE_CLKS(PULSE), .HOLD_CLKS(HOLD)
  ) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
    .buf_sel(buf_sel), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .busy(busy), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  // Behavioural device model
  logic [7:0] page_mem [PAGE];
  int         resp_mode = 0;  // 0 page, 1 id, 2 status
  int         rd_ptr = 0;
  logic [7:0] resp_byte;

  function automatic logic [7:0] id_byte(input int k);
    case (k % IDN)
      0: return 8'h2C;
      1: return 8'hA1;
      2: return 8'h5E;
      default: return 8'h07;
    endcase
  endfunction

  always_comb begin
    if (resp_mode == 1)      resp_byte = id_byte(rd_ptr);
    else if (resp_mode == 2) resp_byte = 8'hE0;
    else                     resp_byte = page_mem[rd_ptr % PAGE];
  end
  assign nand_dq_in = nand_re_n ? 8'h00 : resp_byte;

  // Per-clock monitor and reference bookkeeping
  logic [9:0] ev_q [$];
  int  re_cnt = 0;
  int  low_len = 0;
  int  pulses = 0;
  int  width_bad = 0;
  int  dual_bad = 0;
  int  idle_bad = 0;
  int  rb_bad = 0;
  logic we_prev = 1'b1, re_prev = 1'b1;

  int checks = 0;
  int failures = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!nand_we_n || !nand_re_n) low_len++;
      if (!nand_we_n && !nand_re_n) dual_bad++;
      if (!busy && (!nand_we_n || !nand_re_n)) idle_bad++;
      if (!nand_rb && (!nand_we_n || !nand_re_n)) rb_bad++;
      if (nand_we_n && !we_prev) begin
        ev_q.push_back({nand_cle, nand_ale, nand_dq_out});
        pulses++;
        if (low_len != PULSE) width_bad++;
        low_len = 0;
      end
      if (nand_re_n && !re_prev) begin
        re_cnt++;
        rd_ptr++;
        pulses++;
        if (low_len != PULSE) width_bad++;
        low_len = 0;
      end
      we_prev = nand_we_n;
      re_prev = nand_re_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wr_buf(input int s, input int a, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_sel = 1'(s); buf_addr = 4'(a); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic rd_buf(input int s, input int a, output logic [7:0] d);
    @(negedge clk);
    buf_sel = 1'(s); buf_addr = 4'(a);
    @(negedge clk);
    d = buf_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [15:0] v;
    v = 16'h0;
    for (int p = 0; p < 2000; p++) begin
      rd_reg(3'd4, v);
      if (v[15]) break;
    end
    chk(v[15] == 1'b1, tag, {16'h0, v}, 32'h8000);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [7:0]  b;
    int          re0;
    for (int i = 0; i < PAGE; i++) page_mem[i] = 8'h90 ^ 8'(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", {31'h0, busy}, 0);
    chk({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe} == 6'b111000,
        "R1 pins", {26'h0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 32'h38);
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), v);
      chk(v == 16'h0, "R1 register", {16'h0, v}, 0);
    end

    // R2 command cycle
    wr_reg(3'd0, 16'h1230);
    ev_q.delete();
    wr_reg(3'd4, 16'h0001);
    wait_done("R2 done");
    chk(ev_q.size() == 1, "R2 pulse count", ev_q.size(), 1);
    if (ev_q.size() > 0) chk(ev_q[0] == {2'b10, 8'h30}, "R2 cle/data", {22'h0, ev_q[0]}, {22'h0, 2'b10, 8'h30});

    // R8 sticky done flag
    rd_reg(3'd4, v);
    chk(v[15] == 1'b1, "R8 sticky after read", {16'h0, v}, 32'h8000);
    wr_reg(3'd4, 16'h8000);
    rd_reg(3'd4, v);
    chk(v[15] == 1'b1, "R8 bit15 write keeps", {16'h0, v}, 32'h8000);
    wr_reg(3'd4, 16'h0000);
    rd_reg(3'd4, v);
    chk(v == 16'h0000, "R8 cleared", {16'h0, v}, 0);

    // R3 address cycle
    wr_reg(3'd1, 16'hBEEF);
    ev_q.delete();
    wr_reg(3'd4, 16'h0002);
    wait_done("R3 done");
    chk(ev_q.size() == 1, "R3 pulse count", ev_q.size(), 1);
    if (ev_q.size() > 0) chk(ev_q[0] == {2'b01, 8'hEF}, "R3 ale/data", {22'h0, ev_q[0]}, {22'h0, 2'b01, 8'hEF});

    // R4 / R10 / R13 program transfer from buffer 0 (upper select bits ignored)
    for (int i = 0; i < PAGE; i++) begin
      wr_buf(0, i, 8'(i * 7 + 3));
      wr_buf(1, i, 8'(8'hC0 + i));
    end
    wr_reg(3'd2, 16'hFFFE);
    rd_reg(3'd2, v);
    chk(v == 16'h0000, "R13 select readback", {16'h0, v}, 0);
    nand_rb = 1'b0;
    ev_q.delete();
    wr_reg(3'd4, 16'h0004);
    repeat (20) @(negedge clk);
    chk(ev_q.size() == 0, "R10 no strobe while device busy", ev_q.size(), 0);
    chk(busy == 1'b1, "R10 waiting keeps busy", {31'h0, busy}, 1);
    nand_rb = 1'b1;
    wait_done("R4 done");
    chk(ev_q.size() == PAGE, "R4 byte count", ev_q.size(), PAGE);
    for (int i = 0; i < PAGE && i < ev_q.size(); i++)
      chk(ev_q[i] == {2'b00, 8'(i * 7 + 3)}, "R4 R13 byte order", {22'h0, ev_q[i]}, {22'h0, 2'b00, 8'(i * 7 + 3)});

    // R5 page fetch into buffer 1
    resp_mode = 0; rd_ptr = 0;
    wr_reg(3'd2, 16'h0001);
    re0 = re_cnt;
    wr_reg(3'd4, 16'h0008);
    wait_done("R5 done");
    chk(re_cnt - re0 == PAGE, "R5 read pulses", re_cnt - re0, PAGE);
    for (int i = 0; i < PAGE; i++) begin
      rd_buf(1, i, b);
      chk(b == (8'h90 ^ 8'(i)), "R5 stored byte", {24'h0, b}, {24'h0, 8'h90 ^ 8'(i)});
    end

    // R6 ID read into buffer 0
    resp_mode = 1; rd_ptr = 0;
    wr_reg(3'd2, 16'h0000);
    re0 = re_cnt;
    wr_reg(3'd4, 16'h0010);
    wait_done("R6 done");
    chk(re_cnt - re0 == IDN, "R6 read pulses", re_cnt - re0, IDN);
    for (int i = 0; i < IDN; i++) begin
      rd_buf(0, i, b);
      chk(b == id_byte(i), "R6 id byte", {24'h0, b}, {24'h0, id_byte(i)});
    end
    rd_buf(0, IDN, b);
    chk(b == 8'(IDN * 7 + 3), "R6 tail untouched", {24'h0, b}, {24'h0, 8'(IDN * 7 + 3)});

    // R7 status read into buffer 1
    resp_mode = 2; rd_ptr = 0;
    wr_reg(3'd2, 16'h0001);
    re0 = re_cnt;
    wr_reg(3'd4, 16'h0020);
    wait_done("R7 done");
    chk(re_cnt - re0 == 1, "R7 read pulses", re_cnt - re0, 1);
    rd_buf(1, 0, b);
    chk(b == 8'hE0, "R7 status byte", {24'h0, b}, 32'hE0);
    rd_buf(1, 1, b);
    chk(b == 8'h91, "R7 index1 untouched", {24'h0, b}, 32'h91);

    // R9 busy, active code, ignored launch while busy
    resp_mode = 0; rd_ptr = 0;
    nand_rb = 1'b0;
    ev_q.delete();
    re0 = re_cnt;
    wr_reg(3'd4, 16'h0008);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R9 busy", {31'h0, busy}, 1);
    rd_reg(3'd4, v);
    chk(v == 16'h0008, "R9 active code", {16'h0, v}, 32'h8);
    wr_reg(3'd4, 16'h0001);
    nand_rb = 1'b1;
    wait_done("R9 done");
    repeat (20) @(negedge clk);
    chk(ev_q.size() == 0, "R9 launch while busy ignored", ev_q.size(), 0);
    chk(re_cnt - re0 == PAGE, "R9 single transfer", re_cnt - re0, PAGE);
    re0 = re_cnt;
    wr_reg(3'd4, 16'h0003);
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R9 non-onehot no start", {31'h0, busy}, 0);
    chk(ev_q.size() == 0 && re_cnt == re0, "R9 non-onehot no pulses", ev_q.size() + re_cnt - re0, 0);
    rd_reg(3'd4, v);
    chk(v == 16'h0000, "R8 idle write clears flag", {16'h0, v}, 0);

    // R12 control register and chip enable
    chk(nand_ce_n == 1'b1, "R12 ce idle", {31'h0, nand_ce_n}, 1);
    wr_reg(3'd3, 16'hFFFF);
    rd_reg(3'd3, v);
    chk(v == 16'h01FC, "R12 control mask", {16'h0, v}, 32'h1FC);
    chk(nand_ce_n == 1'b0, "R12 ce forced", {31'h0, nand_ce_n}, 0);
    wr_reg(3'd3, 16'h0000);
    @(negedge clk);
    chk(nand_ce_n == 1'b1, "R12 ce released", {31'h0, nand_ce_n}, 1);

    // R11 and pulse-window rules, gathered from the monitor
    chk(pulses > 0 && width_bad == 0, "R11 pulse width", width_bad, 0);
    chk(dual_bad == 0, "R11 strobes exclusive", dual_bad, 0);
    chk(idle_bad == 0, "R9 no strobe when idle", idle_bad, 0);
    chk(rb_bad == 0, "R10 no strobe while device busy", rb_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule